// File: doc/BRIEF.md
# CAN bit timing generator

This block divides a system clock into time quanta and runs each nominal bit through a one-quantum synchronization segment, a first timing segment and a second timing segment. It emits three one-clock strobes: one where the transmitter should launch a new bit, one where the receive line is sampled, and one on the last clock of each bit. The sampled receive value is held on an output. A protocol layer above uses these strobes to shift bits in and out, and tells the block when the bus is idle so that a falling edge can restart bit timing.

The timing is set by one packed 15-bit word. Each field holds its length minus one. An init flag, set at reset, freezes the timing state, forces the transmit output recessive and is the only condition under which a new timing word is accepted. Falling edges on the receive line adjust the bit. When hard synchronization is enabled, an edge restarts the bit. Otherwise an edge lengthens the first segment or shortens the second, and the adjustment is limited by the jump width.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the init flag is 1 (`in_init` high), `tx_out` is 1 whatever `tx_in` is, and none of the three strobes pulses while init stays set. `tx_out` is also 1 whenever init is set again.
- R2: While init is clear, `tx_out` equals `tx_in`.
- R3: A write on `cfg_wr` is accepted only while init is set. A write while init is clear has no effect on the bit timing that follows.
- R4: Timing word layout: bits [5:0] = P (prescale), [7:6] = J, [11:8] = A, [14:12] = B. One quantum is P+1 clocks. The first segment is A+1 quanta, the second is B+1 quanta, and a bit lasts (P+1)*(A+B+3) clocks. The reset word is 0x1600.
- R5: `tx_pt_stb` pulses for one clock on the first clock of each bit's synchronization segment. The first pulse comes in the first clock after init is cleared through `ctrl_wr` with `ctrl_init`=0.
- R6: `sample_stb` pulses on the last clock of the first segment, which is (P+1)*(A+2)-1 clocks after `tx_pt_stb`. `rx_bit` takes the value of `rx` at that clock.
- R7: `bit_end_stb` pulses on the last clock of each bit, and `tx_pt_stb` follows on the next clock.
- R8: With `hard_sync_en` high, a falling edge on `rx` ends the current bit without a sample or end strobe. The next clock begins a new synchronization segment.
- R9: With `hard_sync_en` low, a falling edge in quantum k (counted from 1) of the first segment lengthens that segment by min(k, J+1) quanta.
- R10: With `hard_sync_en` low, a falling edge in the second segment with r quanta left (the current one included) ends the bit on that clock if r <= J+1. Otherwise it shortens the segment by J+1 quanta.
- R11: Falling edges in the synchronization segment do not adjust the bit. Rising edges do not adjust the bit. Only the first adjusting edge in a bit takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the init flag |
| ctrl_init | input | 1 | Init flag value written on `ctrl_wr` |
| cfg_wr | input | 1 | Write strobe for the timing word |
| cfg_word | input | 15 | Packed timing word |
| rx | input | 1 | Receive line, synchronous to `clk` |
| tx_in | input | 1 | Bit to transmit from the protocol layer |
| hard_sync_en | input | 1 | Bus idle: falling edges restart the bit |
| tx_out | output | 1 | Transmit line, recessive (1) in init |
| sample_stb | output | 1 | Sample point strobe |
| tx_pt_stb | output | 1 | Bit start (transmit point) strobe |
| bit_end_stb | output | 1 | Last clock of bit strobe |
| rx_bit | output | 1 | Last sampled receive value |
| in_init | output | 1 | Current init flag |

## Verification
The embedded assertions check several properties on every cycle. The transmit line stays recessive during init. The timing word is frozen outside init. The prescaler never passes its limit. A bit end is always followed by a bit start, and a hard synchronization always restarts the bit on the next clock. The exact clock positions of sample points and bit boundaries can only be shown by the bench's scenarios. These include the sweep over field encodings and prescale values, the placement of resynchronization edges at chosen quanta, the jump-width limit, the single-adjustment rule and the rejection of timing writes outside init.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter logic [14:0] RST_TIMING = 15'h1600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic        ctrl_init,
  input  logic        cfg_wr,
  input  logic [14:0] cfg_word,
  input  logic        rx,
  input  logic        tx_in,
  input  logic        hard_sync_en,
  output logic        tx_out,
  output logic        sample_stb,
  output logic        tx_pt_stb,
  output logic        bit_end_stb,
  output logic        rx_bit,
  output logic        in_init
);

  localparam int PRE_W = 6;
  localparam int LEN_W = 6;

  typedef enum logic [1:0] {S_SYNC, S_TS1, S_TS2} seg_t;

  logic [14:0]      cfg_q;
  logic             init_q;
  seg_t             seg_q;
  logic [PRE_W-1:0] pre_q;
  logic [LEN_W-1:0] qc_q;
  logic [LEN_W-1:0] len_q;
  logic             rs_done_q;
  logic             rx_q;

  wire [PRE_W-1:0] pre_lim = cfg_q[5:0];
  wire [LEN_W-1:0] sjw_len = LEN_W'(cfg_q[7:6]) + LEN_W'(1);
  wire [LEN_W-1:0] ts1_len = LEN_W'(cfg_q[11:8]) + LEN_W'(1);
  wire [LEN_W-1:0] ts2_len = LEN_W'(cfg_q[14:12]) + LEN_W'(1);

  wire run    = ~init_q;
  wire tq_end = (pre_q == pre_lim);
  wire fall   = rx_q & ~rx;
  wire hsync  = run & fall & hard_sync_en;
  wire rs_ok  = run & fall & ~hard_sync_en & ~rs_done_q;
  wire rs1    = rs_ok & (seg_q == S_TS1);
  wire rs2    = rs_ok & (seg_q == S_TS2);

  wire [LEN_W-1:0] phase1 = qc_q + LEN_W'(1);
  wire [LEN_W-1:0] ext    = (phase1 > sjw_len) ? sjw_len : phase1;
  wire [LEN_W-1:0] rem2   = len_q - qc_q;
  wire             cut    = rs2 & (rem2 <= sjw_len);

  logic [LEN_W-1:0] len_eff;
  always_comb begin
    if (rs1)      len_eff = len_q + ext;
    else if (rs2) len_eff = len_q - sjw_len;
    else          len_eff = len_q;
  end

  wire seg_last = tq_end & (qc_q == len_eff - LEN_W'(1));
  wire restart  = hsync | cut;

  assign sample_stb  = run & ~restart & (seg_q == S_TS1) & seg_last;
  assign bit_end_stb = run & ~hsync & (((seg_q == S_TS2) & seg_last) | cut);
  assign tx_pt_stb   = run & (seg_q == S_SYNC) & (pre_q == '0);
  assign tx_out      = init_q | tx_in;
  assign in_init     = init_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q    <= 1'b1;
      cfg_q     <= RST_TIMING;
      seg_q     <= S_SYNC;
      pre_q     <= '0;
      qc_q      <= '0;
      len_q     <= LEN_W'(1);
      rs_done_q <= 1'b0;
      rx_q      <= 1'b1;
      rx_bit    <= 1'b1;
    end else begin
      rx_q <= rx;
      if (ctrl_wr) init_q <= ctrl_init;
      if (cfg_wr && init_q) cfg_q <= cfg_word;
      if (sample_stb) rx_bit <= rx;
      if (!run || restart) begin
        seg_q     <= S_SYNC;
        pre_q     <= '0;
        qc_q      <= '0;
        len_q     <= LEN_W'(1);
        rs_done_q <= 1'b0;
      end else begin
        if (rs1 || rs2) rs_done_q <= 1'b1;
        len_q <= len_eff;
        if (tq_end) begin
          pre_q <= '0;
          if (seg_last) begin
            qc_q <= '0;
            case (seg_q)
              S_SYNC: begin
                seg_q <= S_TS1;
                len_q <= ts1_len;
              end
              S_TS1: begin
                seg_q <= S_TS2;
                len_q <= ts2_len;
              end
              default: begin
                seg_q     <= S_SYNC;
                len_q     <= LEN_W'(1);
                rs_done_q <= 1'b0;
              end
            endcase
          end else begin
            qc_q <= qc_q + LEN_W'(1);
          end
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
    end
  end

  a_r1_recessive_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> tx_out);

  a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |=> $stable(cfg_q));

  a_r4_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= pre_lim);

  a_r7_end_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end_stb && !(ctrl_wr && ctrl_init)) |=> tx_pt_stb);

  a_r8_hsync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !(ctrl_wr && ctrl_init)) |=> tx_pt_stb);

  a_r6_sample_leads_ts2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !(ctrl_wr && ctrl_init)) |=> (seg_q == S_TS2));

  a_r11_single_adjust: assert property (@(posedge clk) disable iff (!rst_n)
    (rs1 && !(ctrl_wr && ctrl_init)) |=> rs_done_q);

endmodule

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0, ctrl_init = 1'b0, cfg_wr = 1'b0;
  logic [14:0] cfg_word = '0;
  logic        rx = 1'b1, tx_in = 1'b1, hard_sync_en = 1'b0;
  logic        tx_out, sample_stb, tx_pt_stb, bit_end_stb, rx_bit, in_init;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_init(ctrl_init),
    .cfg_wr(cfg_wr), .cfg_word(cfg_word), .rx(rx), .tx_in(tx_in),
    .hard_sync_en(hard_sync_en), .tx_out(tx_out), .sample_stb(sample_stb),
    .tx_pt_stb(tx_pt_stb), .bit_end_stb(bit_end_stb), .rx_bit(rx_bit),
    .in_init(in_init));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [14:0] w);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_init = 1'b1;
    @(negedge clk); ctrl_wr = 1'b0; cfg_wr = 1'b1; cfg_word = w;
    @(negedge clk); cfg_wr = 1'b0; ctrl_wr = 1'b1; ctrl_init = 1'b0;
    @(negedge clk); ctrl_wr = 1'b0;
    #1;
  endtask

  // Starts at a negedge where tx_pt_stb is seen (offset 0).
  task automatic measure(input int e1, input int r1, input int e2,
                         output int samp, output int endo, output int txpt);
    samp = -1; endo = -1; txpt = -1;
    if (e1 == 0) rx = 1'b0; else rx = 1'b1;
    for (int off = 1; off < 400; off++) begin
      @(negedge clk);
      if (off == e1 || off == e2) rx = 1'b0;
      if (off == r1) rx = 1'b1;
      #1;
      if (sample_stb && samp < 0) samp = off;
      if (bit_end_stb && endo < 0) endo = off;
      if (tx_pt_stb) begin
        txpt = off;
        break;
      end
    end
  endtask

  task automatic wait_txpt();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (tx_pt_stb) break;
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s, e, t, quiet, per;
    tx_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    quiet = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1;
      if (sample_stb || tx_pt_stb || bit_end_stb || !tx_out || !in_init) quiet = 0;
    end
    chk(quiet == 1, "R1 reset quiet and recessive", quiet, 1);

    // R5: first bit starts right after init clears, with reset word 0x1600
    @(negedge clk); ctrl_wr = 1'b1; ctrl_init = 1'b0;
    @(negedge clk); ctrl_wr = 1'b0; #1;
    chk(tx_pt_stb == 1'b1, "R5 first tx point after init clear", tx_pt_stb, 1);
    chk(tx_out == 1'b0, "R2 tx_out follows tx_in", tx_out, 0);
    measure(-1, -1, -1, s, e, t);
    chk(s == 7, "R6 sample offset reset word", s, 7);
    chk(t == 10, "R4 period reset word", t, 10);
    chk(rx_bit == 1'b1, "R6 rx_bit high sample", rx_bit, 1);

    // R4/R6/R7 sweep over encodings and prescale values
    for (int bi = 0; bi < 3; bi++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 8; b++) begin
          int p;
          p = (bi == 0) ? 0 : (bi == 1) ? 1 : 3;
          per = (p + 1) * (a + b + 3);
          do_cfg(15'((b << 12) | (a << 8) | (1 << 6) | p));
          chk(tx_pt_stb == 1'b1, "R5 tx point after reconfig", tx_pt_stb, 1);
          measure(-1, -1, -1, s, e, t);
          chk(s == (p + 1) * (a + 2) - 1, "R6 sample offset sweep", s, (p + 1) * (a + 2) - 1);
          chk(e == per - 1, "R7 bit end sweep", e, per - 1);
          chk(t == per, "R4 bit period sweep", t, per);
        end
      end
    end

    // Resync scenarios: A=5 (6 tq), B=3 (4 tq), J=1 (2 tq), P=0 -> period 11, sample 6
    do_cfg(15'h3540);
    measure(-1, -1, -1, s, e, t);
    chk(s == 6 && t == 11, "R4 nominal resync config", s * 100 + t, 611);
    measure(0, -1, -1, s, e, t);
    chk(s == 6 && t == 11, "R11 edge in sync segment ignored", s * 100 + t, 611);
    measure(2, -1, -1, s, e, t);
    chk(s == 8, "R9 lengthen by phase error", s, 8);
    chk(t == 13, "R9 lengthened period", t, 13);
    chk(rx_bit == 1'b0, "R6 rx_bit low sample", rx_bit, 0);
    measure(5, -1, -1, s, e, t);
    chk(s == 8 && t == 13, "R9 lengthen capped at jump width", s * 100 + t, 813);
    measure(8, -1, -1, s, e, t);
    chk(e == 8 && t == 9 && s == 6, "R10 shorten by jump width", e * 100 + t, 809);
    measure(9, -1, -1, s, e, t);
    chk(e == 9 && t == 10, "R10 early end when few quanta remain", e * 100 + t, 910);
    measure(2, 3, 4, s, e, t);
    chk(s == 8 && t == 13, "R11 only first edge adjusts", s * 100 + t, 813);
    measure(-1, 3, -1, s, e, t);
    chk(s == 6 && t == 11, "R11 rising edge ignored", s * 100 + t, 611);

    hard_sync_en = 1'b1;
    measure(4, -1, -1, s, e, t);
    chk(t == 5 && s == -1 && e == -1, "R8 hard sync restarts bit", t, 5);
    hard_sync_en = 1'b0;
    measure(-1, -1, -1, s, e, t);

    // R3: write outside init is ignored
    @(negedge clk); cfg_wr = 1'b1; cfg_word = 15'h1600;
    @(negedge clk); cfg_wr = 1'b0;
    wait_txpt();
    measure(-1, -1, -1, s, e, t);
    chk(s == 6 && t == 11, "R3 cfg write outside init ignored", s * 100 + t, 611);

    // R1: re-entering init forces recessive and stops strobes
    @(negedge clk); ctrl_wr = 1'b1; ctrl_init = 1'b1;
    @(negedge clk); ctrl_wr = 1'b0;
    quiet = 1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk); #1;
      if (sample_stb || tx_pt_stb || bit_end_stb || !tx_out) quiet = 0;
    end
    chk(quiet == 1, "R1 init re-entry quiet and recessive", quiet, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule